// File: doc/BRIEF.md
# Address-Range Cache Maintenance Engine

This block performs clean and invalidate work on a shared last-level cache across a physical address range that software programs. Software loads a range base and a range limit into two 64-bit registers, then writes a command register. That write selects one of three maintenance kinds and starts the walk. The engine steps through the range one 64-byte line at a time. For each line it presents a request to the cache arrays on a request/acknowledge port. An activity flag in the command register stays at 1 until the last line has been acknowledged, and software polls that flag to learn when the operation is complete.

The range is half-open. The base is rounded down to a line boundary and the limit is rounded up to one. Addresses are 40 bits wide. The walker is a three-state machine:

- `ST_IDLE`: waits for a command write.
- `ST_LAUNCH`: spends one cycle comparing the rounded bounds.
- `ST_ISSUE`: holds a line request until it is acknowledged.

The transitions are:

- `ST_IDLE` goes to `ST_LAUNCH` on a command write.
- `ST_LAUNCH` goes to `ST_ISSUE` when the range is not empty.
- `ST_LAUNCH` goes to `ST_IDLE` when the range is empty.
- `ST_ISSUE` stays in `ST_ISSUE` on an acknowledge that is not the last line, and also while no acknowledge arrives.
- `ST_ISSUE` goes to `ST_IDLE` on the acknowledge of the last line.

Top module: `cmo_range_engine`

## Requirements
- R1: After reset, the range base, the range limit and the command register all read 0, and `line_req` is low.
- R2: The range base is at byte offset 0x0 and the range limit at 0x8. A read returns bits 39:0 of the last value written to that register, with bits 63:40 reading 0.
- R3: Offset 0x10 is the command register. A write to it while idle latches bits 2:1 as the operation kind and sets the activity flag, whatever the value of bit 0. A read returns the kind in bits 2:1 and the activity flag in bit 0, with every other bit 0. The kind encoding is 0 for clean then invalidate, 1 for invalidate with no writeback, and 2 for clean with lines left valid.
- R4: A command write while the engine is active has no effect. The operation kind and the request stream continue unchanged.
- R5: While `line_req` is high and `line_ack` is low, `line_req`, `line_addr` and `line_op` hold their values on the next cycle.
- R6: The engine requests every line from the base rounded down to a 64-byte boundary up to, but not including, the limit rounded up to a 64-byte boundary. Each line is requested exactly once, in ascending order, with `line_op` equal to the latched kind. The engine moves to the next line only after an acknowledge.
- R7: When the rounded limit is less than or equal to the rounded base, no line is requested. The activity flag reads 1 for exactly one cycle after the command write.
- R8: The activity flag reads 0 in the cycle right after the acknowledge of the last line.
- R9: Reads at any offset other than 0x0, 0x8 and 0x10 return 0. Writes to those other offsets change no register.
- R10: A range that reaches the top of the 40-bit space, with a limit above 0xFF_FFFF_FFC0, is walked correctly up to the last line 0xFF_FFFF_FFC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 10 | Register byte offset |
| bus_wdata | input | 64 | Register write data |
| bus_rdata | output | 64 | Register read data, a combinational function of `bus_addr` |
| line_req | output | 1 | Line maintenance request valid |
| line_addr | output | 40 | Line-aligned physical address of the request |
| line_op | output | 2 | Operation kind of the request |
| line_ack | input | 1 | Cache arrays accept the current request |

## Verification
Some behaviours are checked by assertions on every cycle:

- a stalled request holds its line, operation and valid (R5);
- request addresses are line-aligned and each acknowledged line is followed by the one 64 bytes above it (R6);
- the kind register holds while the engine is active (R4);
- an empty range drops the activity flag right after its launch cycle (R7);
- the upper address bits read back as zero (R2).

Other behaviours can only be shown by the bench's scenarios, where a scoreboard matches each handshake against lines the bench computes itself. These are:

- the full coverage of a range, with the exact first and last lines after rounding (R6, R10);
- the cycle in which the flag falls (R8);
- that a command written mid-walk leaves the stream unchanged (R4).

The scenarios use both an acknowledge every cycle and an acknowledge every third cycle.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_ISSUE  = 2'd2
    } walk_state_e;

    typedef enum logic [1:0] {
        OP_CLEAN_INV  = 2'd0,
        OP_DROP       = 2'd1,
        OP_CLEAN_KEEP = 2'd2,
        OP_SPARE      = 2'd3
    } maint_op_e;

    localparam int OFF_BASE  = 'h00;
    localparam int OFF_LIMIT = 'h08;
    localparam int OFF_CMD   = 'h10;
    localparam int REG_W     = 64;

endpackage

// File: rtl/cmo_regfile.sv
module cmo_regfile
    import cmo_pkg::*;
#(
    parameter int PA_W   = 40,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [1:0]        stat_op,
    input  logic              stat_busy,
    output logic [PA_W-1:0]   base_q,
    output logic [PA_W-1:0]   limit_q,
    output logic              cmd_stb,
    output logic [1:0]        cmd_op
);

    localparam int PAD_W = REG_W - PA_W;

    logic hit_base, hit_limit, hit_cmd;
    logic unused_wbits;

    always_comb begin
        hit_base  = (bus_addr == ADDR_W'(OFF_BASE));
        hit_limit = (bus_addr == ADDR_W'(OFF_LIMIT));
        hit_cmd   = (bus_addr == ADDR_W'(OFF_CMD));
    end

    assign unused_wbits = ^{bus_wdata[REG_W-1:PA_W], bus_wdata[0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (bus_wr) begin
            if (hit_base)  base_q  <= bus_wdata[PA_W-1:0];
            if (hit_limit) limit_q <= bus_wdata[PA_W-1:0];
        end
    end

    always_comb begin
        cmd_stb = bus_wr && hit_cmd;
        cmd_op  = bus_wdata[2:1];
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_base)
            bus_rdata = {{PAD_W{1'b0}}, base_q};
        else if (hit_limit)
            bus_rdata = {{PAD_W{1'b0}}, limit_q};
        else if (hit_cmd)
            bus_rdata = {{(REG_W-3){1'b0}}, stat_op, stat_busy};
    end

    // R2: upper address bits are never returned
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_base || hit_limit) |-> (bus_rdata[REG_W-1:PA_W] == '0));

    // R9: unmapped offsets read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_base || hit_limit || hit_cmd) |-> (bus_rdata == '0));

endmodule

// File: rtl/cmo_walker.sv
module cmo_walker
    import cmo_pkg::*;
#(
    parameter int PA_W       = 40,
    parameter int LINE_BYTES = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic [1:0]      launch_op,
    input  logic [PA_W-1:0] base_pa,
    input  logic [PA_W-1:0] limit_pa,
    input  logic            line_ack,
    output logic            line_req,
    output logic [PA_W-1:0] line_addr,
    output logic [1:0]      line_op,
    output logic            busy,
    output logic [1:0]      op_q
);

    localparam int LS   = $clog2(LINE_BYTES);
    localparam int CW   = PA_W + 1;
    localparam logic [CW-1:0] STEP = CW'(LINE_BYTES);
    localparam logic [CW-1:0] LOW_MASK = CW'(LINE_BYTES - 1);

    walk_state_e state_q, state_nx;
    logic [CW-1:0] cursor_q, limit_r;
    logic [CW-1:0] lo_round, hi_round, cursor_step;
    logic          last_line;

    always_comb begin
        lo_round    = {1'b0, base_pa} & ~LOW_MASK;
        hi_round    = ({1'b0, limit_pa} + LOW_MASK) & ~LOW_MASK;
        cursor_step = cursor_q + STEP;
        last_line   = (cursor_step >= limit_r);
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = (cursor_q < limit_r) ? ST_ISSUE : ST_IDLE;
            ST_ISSUE:  if (line_ack && last_line) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cursor_q <= '0;
            limit_r  <= '0;
            op_q     <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_IDLE && launch) begin
                cursor_q <= lo_round;
                limit_r  <= hi_round;
                op_q     <= launch_op;
            end else if (state_q == ST_ISSUE && line_ack) begin
                cursor_q <= cursor_step;
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        line_req  = (state_q == ST_ISSUE);
        line_addr = cursor_q[PA_W-1:0];
        line_op   = op_q;
    end

    // R5: stalled request holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (line_req && !line_ack) |=>
            (line_req && $stable(line_addr) && $stable(line_op)));

    // R6: line alignment of every request
    a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |-> (line_addr[LS-1:0] == '0));

    // R6: ascending by one line after each acknowledge
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (line_req && line_ack && !last_line) |=>
            (line_req && line_addr == $past(line_addr) + PA_W'(LINE_BYTES)));

    // R4: kind holds while active
    a_r4_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op_q));

    // R7: empty range ends after the launch cycle
    a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LAUNCH && cursor_q >= limit_r) |=> (!busy && !line_req));

endmodule

// File: rtl/cmo_range_engine.sv
module cmo_range_engine
    import cmo_pkg::*;
#(
    parameter int PA_W       = 40,
    parameter int ADDR_W     = 10,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic [63:0]       bus_rdata,
    output logic              line_req,
    output logic [PA_W-1:0]   line_addr,
    output logic [1:0]        line_op,
    input  logic              line_ack
);

    logic [PA_W-1:0] base_q, limit_q;
    logic            cmd_stb, busy;
    logic [1:0]      cmd_op, op_q;

    cmo_regfile #(.PA_W(PA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .stat_op   (op_q),
        .stat_busy (busy),
        .base_q    (base_q),
        .limit_q   (limit_q),
        .cmd_stb   (cmd_stb),
        .cmd_op    (cmd_op)
    );

    cmo_walker #(.PA_W(PA_W), .LINE_BYTES(LINE_BYTES)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (cmd_stb),
        .launch_op (cmd_op),
        .base_pa   (base_q),
        .limit_pa  (limit_q),
        .line_ack  (line_ack),
        .line_req  (line_req),
        .line_addr (line_addr),
        .line_op   (line_op),
        .busy      (busy),
        .op_q      (op_q)
    );

endmodule

// File: tb/sim_cmo_range_engine.sv
module sim_cmo_range_engine;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        line_req;
    logic [39:0] line_addr;
    logic [1:0]  line_op;
    logic        line_ack = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_pop_cyc = -1;
    bit slow_ack = 1'b0;
    logic [41:0] expq[$];

    cmo_range_engine u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_req(line_req),
        .line_addr(line_addr), .line_op(line_op), .line_ack(line_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // ack driver and scoreboard monitor
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n++;
            line_ack = line_req && (!slow_ack || (n % 3 == 0));
            if (line_ack) begin
                if (expq.size() == 0) begin
                    check("R6 unexpected line", {22'b0, line_op, line_addr}, 64'hDEAD);
                end else begin
                    logic [41:0] e;
                    e = expq.pop_front();
                    check("R6 line/op", {22'b0, line_op, line_addr}, {22'b0, e});
                    if (expq.size() == 0) last_pop_cyc = cyc;
                end
            end
        end
    end

    task automatic push_range(input logic [39:0] s, input logic [39:0] e, input logic [1:0] op);
        logic [40:0] lo, hi;
        lo = {1'b0, s} & ~41'h3F;
        hi = ({1'b0, e} + 41'h3F) & ~41'h3F;
        for (logic [40:0] a = lo; a < hi; a += 41'h40) expq.push_back({op, a[39:0]});
    endtask

    task automatic wait_idle(input string req);
        logic [63:0] d;
        int idle_cyc = -1;
        for (int i = 0; i < 2000; i++) begin
            rd(10'h10, d);
            if (d[0] == 1'b0) begin idle_cyc = cyc; break; end
        end
        check({req, " idle reached"}, (idle_cyc >= 0) ? 64'd1 : 64'd0, 64'd1);
        check({req, " queue drained"}, 64'(expq.size()), 64'd0);
        check({req, " R8 idle cycle"}, 64'(idle_cyc), 64'(last_pop_cyc + 1));
    endtask

    task automatic run_op(input string req, input logic [39:0] s, input logic [39:0] e,
                          input logic [1:0] op, input bit slow);
        logic [63:0] d;
        slow_ack = slow;
        wr(10'h00, {24'h0, s});
        wr(10'h08, {24'h0, e});
        push_range(s, e, op);
        wr(10'h10, {61'b0, op, 1'b0});
        bus_addr = 10'h10;
        #1 d = bus_rdata;
        check({req, " R3 cmd readback"}, d, {61'b0, op, 1'b1});
        wait_idle(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check("watchdog", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(10'h00, d); check("R1 base", d, 64'd0);
        rd(10'h08, d); check("R1 limit", d, 64'd0);
        rd(10'h10, d); check("R1 cmd", d, 64'd0);
        check("R1 line_req", {63'b0, line_req}, 64'd0);

        // R2 readback masking
        wr(10'h00, 64'hFFFF_FF12_3456_789A);
        rd(10'h00, d); check("R2 base", d, 64'h0000_0012_3456_789A);
        wr(10'h08, 64'hABCD_EF98_7654_3210);
        rd(10'h08, d); check("R2 limit", d, 64'h0000_0098_7654_3210);

        // R9 unmapped offsets
        wr(10'h18, 64'h1234);
        wr(10'h200, 64'h5678);
        rd(10'h18, d); check("R9 read 0x18", d, 64'd0);
        rd(10'h200, d); check("R9 read 0x200", d, 64'd0);
        rd(10'h00, d); check("R9 base intact", d, 64'h0000_0012_3456_789A);
        rd(10'h10, d); check("R9 cmd intact", d, 64'd0);

        // R6 / R3 walks with various kinds and ack patterns
        run_op("R6 aligned clean-inv", 40'h1000, 40'h1200, 2'd0, 1'b0);
        run_op("R6 unaligned drop slow", 40'h2030, 40'h20C1, 2'd1, 1'b1);
        run_op("R6 single line keep", 40'h3010, 40'h3020, 2'd2, 1'b0);
        run_op("R10 top of space", 40'hFF_FFFF_FF80, 40'hFF_FFFF_FFFF, 2'd2, 1'b1);

        // R4 command while active
        slow_ack = 1'b1;
        wr(10'h00, 64'h8000);
        wr(10'h08, 64'h8200);
        push_range(40'h8000, 40'h8200, 2'd2);
        wr(10'h10, 64'h5);
        wr(10'h10, 64'h2);
        rd(10'h10, d); check("R4 cmd unchanged", d, 64'h5);
        wait_idle("R4 stream");

        // R7 empty ranges
        wr(10'h00, 64'h3000);
        wr(10'h08, 64'h3000);
        wr(10'h10, 64'h2);
        bus_addr = 10'h10;
        #1 d = bus_rdata;
        check("R7 busy one cycle", d, 64'h3);
        rd(10'h10, d); check("R7 busy cleared", d, 64'h2);
        wr(10'h00, 64'h4000);
        wr(10'h08, 64'h3000);
        wr(10'h10, 64'h0);
        repeat (4) @(negedge clk);
        rd(10'h10, d); check("R7 reversed idle", d, 64'h0);
        check("R7 no requests", 64'(expq.size()), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule